// File: doc/BRIEF.md
# Two-Lane Complex Sample Deserializer

The block rebuilds complex samples from an ADC output link with two serial data lanes and a frame clock. The lanes and the frame clock have already been sampled into the fabric, one bit per clock cycle. Each 20-bit word is split between the lanes. One lane carries the odd-numbered bits and the other carries the even-numbered bits. Both lanes send the most significant bit first. The frame clock is not a word strobe. It stays high for the ten bit periods that carry the in-phase word and low for the ten that carry the quadrature word. One frame of twenty bit periods therefore holds one complex sample.

The block locks onto the frame clock before it trusts any data. It tracks its place inside each frame and checks every frame-clock bit against the expected shape. At the end of each good frame it outputs the I and Q words together with a one-cycle valid pulse. Two run-time controls fix a mirrored spectrum in logic. The first negates Q, which conjugates the sample. The second exchanges the I and Q outputs. Words are two's-complement values and are not rescaled.

Top module: `iq_lane_deser`

## Requirements
- R1: In each bit period, lane odd_i carries word bit 19-2k and lane even_i carries bit 18-2k, where k runs 0 to 9 in arrival order. The rebuilt word has the same bit positions, with no rescaling or sign change.
- R2: Bits that arrive while frame_i is 1 make up the I word. The ten bits that follow while frame_i is 0 make up the Q word of the same sample.
- R3: locked_o goes to 1 only after frame_i rises from 0 to 1 and then shows exactly ten 1s and ten 0s. It rises in the cycle after the tenth 0 is sampled, and it is still 0 when the 19th bit of that frame is sampled.
- R4: Out of reset, valid_o, locked_o, i_o and q_o are all 0. While the block searches for a frame (frame_i held low), valid_o stays 0, and valid_o is never 1 while locked_o is 0.
- R5: Each correct frame gives exactly one valid_o pulse of one cycle. The pulse comes in the cycle after the last Q bit is sampled, and i_o/q_o keep their values until the next pulse.
- R6: A frame_i bit that does not match the expected shape clears locked_o in the cycle after it is sampled, and that frame gives no valid_o. The block locks again, with a valid pulse, at the end of the next correct frame that starts with a 0-to-1 rise.
- R7: When swap_iq_i is 1 at the end of a frame, i_o takes the received Q word and q_o takes the received I word.
- R8: When neg_q_i is 1 at the end of a frame, the Q word is replaced by its 20-bit two's-complement negation, so 0x80000 maps to itself. The negation happens before any swap, so with both controls set, i_o is the negated Q and q_o is I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Sampled frame clock, 1 for the I half, 0 for the Q half |
| odd_i | input | 1 | Lane carrying the odd-numbered word bits |
| even_i | input | 1 | Lane carrying the even-numbered word bits |
| swap_iq_i | input | 1 | Exchange the I and Q outputs |
| neg_q_i | input | 1 | Negate Q (conjugate the sample) |
| valid_o | output | 1 | One-cycle pulse when a new sample is presented |
| i_o | output | 20 | In-phase word, two's complement |
| q_o | output | 20 | Quadrature word, two's complement |
| locked_o | output | 1 | Frame alignment held |

## Verification
All results come through one register stage. The clock edge that samples a frame's last Q bit is the same edge that raises valid_o, loads i_o/q_o and, on the first good frame, raises locked_o. The edge that samples a bad frame-clock bit is the edge that clears locked_o. The bench drives each bit half a cycle before the edge and reads every output one time unit after that same edge. Each observation is therefore tied to the bit that caused it. Valid pulses are counted across the whole of each frame. This shows that a frame gives exactly one pulse, on its last bit, or none at all when the frame is broken.

// File: rtl/iq_deser_pkg.sv
package iq_deser_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_TRAIN  = 2'd1,
    ST_LOCK   = 2'd2
  } align_st_e;
endpackage

// File: rtl/iq_frame_track.sv
module iq_frame_track
  import iq_deser_pkg::*;
#(
  parameter int unsigned HALF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic done_o,
  output logic locked_o
);
  localparam int unsigned FRAME = 2 * HALF;
  localparam int unsigned POS_W = $clog2(FRAME);

  align_st_e        st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             prev_q;
  logic             rise, exp_hi, match, last;

  assign rise   = frame_i & ~prev_q;
  assign exp_hi = pos_q < POS_W'(HALF);
  assign match  = frame_i == exp_hi;
  assign last   = pos_q == POS_W'(FRAME - 1);

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    done_o = 1'b0;
    if (st_q == ST_SEARCH) begin
      if (rise) begin
        st_d  = ST_TRAIN;
        pos_d = POS_W'(1);
      end
    end else if (match) begin
      if (last) begin
        st_d   = ST_LOCK;
        pos_d  = '0;
        done_o = 1'b1;
      end else begin
        pos_d = pos_q + POS_W'(1);
      end
    end else if (rise) begin
      // a misplaced rise may itself be the start of a real frame
      st_d  = ST_TRAIN;
      pos_d = POS_W'(1);
    end else begin
      st_d  = ST_SEARCH;
      pos_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEARCH;
      pos_q  <= '0;
      prev_q <= 1'b1;  // demand an observed 0 before the first rise
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      prev_q <= frame_i;
    end
  end

  assign locked_o = st_q == ST_LOCK;

  p_lock_after_low_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> !$past(frame_i));

  p_break_drops_lock_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && (frame_i != exp_hi)) |=> !locked_o);
endmodule

// File: rtl/iq_lane_pack.sv
module iq_lane_pack #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              odd_i,
  input  logic              even_i,
  output logic [WORD_W-1:0] i_word_o,
  output logic [WORD_W-1:0] q_word_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    // Q keeps two bits fewer: its last pair is taken straight off the lanes
    localparam int unsigned KEEP = (h == 0) ? WORD_W : WORD_W - 2;
    localparam logic        SEL  = (h == 0);
    logic [KEEP-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               sh_q <= '0;
      else if (frame_i == SEL)   sh_q <= {sh_q[KEEP-3:0], odd_i, even_i};
    end
  end

  assign i_word_o = g_half[0].sh_q;
  assign q_word_o = {g_half[1].sh_q, odd_i, even_i};
endmodule

// File: rtl/iq_out_stage.sv
module iq_out_stage #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] i_word_i,
  input  logic [WORD_W-1:0] q_word_i,
  input  logic              swap_i,
  input  logic              neg_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] i_o,
  output logic [WORD_W-1:0] q_o
);
  logic [WORD_W-1:0] q_adj;

  assign q_adj = neg_i ? (WORD_W'(0) - q_word_i) : q_word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      i_o     <= '0;
      q_o     <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        i_o <= swap_i ? q_adj : i_word_i;
        q_o <= swap_i ? i_word_i : q_adj;
      end
    end
  end

  p_word_hold_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(i_o) && $stable(q_o)));
endmodule

// File: rtl/iq_lane_deser.sv
module iq_lane_deser #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              odd_i,
  input  logic              even_i,
  input  logic              swap_iq_i,
  input  logic              neg_q_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] i_o,
  output logic [WORD_W-1:0] q_o,
  output logic              locked_o
);
  localparam int unsigned HALF = WORD_W / 2;

  logic              done;
  logic [WORD_W-1:0] i_word, q_word;

  iq_frame_track #(.HALF(HALF)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .done_o   (done),
    .locked_o (locked_o)
  );

  iq_lane_pack #(.WORD_W(WORD_W)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .odd_i    (odd_i),
    .even_i   (even_i),
    .i_word_o (i_word),
    .q_word_o (q_word)
  );

  iq_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (done),
    .i_word_i (i_word),
    .q_word_i (q_word),
    .swap_i   (swap_iq_i),
    .neg_i    (neg_q_i),
    .valid_o  (valid_o),
    .i_o      (i_o),
    .q_o      (q_o)
  );

  p_valid_needs_lock_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_o);

  p_valid_single_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: tb/sim_iq_lane_deser.sv
module sim_iq_lane_deser;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame = 1'b0, odd = 1'b0, even = 1'b0, swap = 1'b0, neg = 1'b0;
  logic valid, locked;
  logic [W-1:0] i_w, q_w;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  logic         obs_valid, obs_locked;
  logic [W-1:0] obs_i, obs_q;
  int           vld_cnt;
  logic         vld_last, lk_mark, lk_18;
  logic [W-1:0] cap_i, cap_q, mid_i, mid_q;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iq_lane_deser #(.WORD_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .odd_i(odd), .even_i(even),
    .swap_iq_i(swap), .neg_q_i(neg), .valid_o(valid), .i_o(i_w), .q_o(q_w),
    .locked_o(locked)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_bit(input logic f, input logic o, input logic e);
    @(negedge clk);
    frame = f; odd = o; even = e;
    @(posedge clk);
    #1;
    obs_valid = valid; obs_locked = locked; obs_i = i_w; obs_q = q_w;
  endtask

  // brk >= 0 inverts the frame bit at that position
  task automatic send_frame(input logic [W-1:0] iw, input logic [W-1:0] qw, input int brk);
    vld_cnt = 0; vld_last = 1'b0; lk_mark = 1'b1; lk_18 = 1'b1;
    for (int k = 0; k < 2 * (W / 2); k++) begin
      logic hi;
      int idx;
      logic [W-1:0] wd;
      logic f;
      hi  = k < W / 2;
      idx = hi ? k : k - W / 2;
      wd  = hi ? iw : qw;
      f   = (k == brk) ? ~hi : hi;
      drive_bit(f, wd[W-1-2*idx], wd[W-2-2*idx]);
      if (obs_valid) begin
        vld_cnt++;
        cap_i = obs_i; cap_q = obs_q;
        if (k == 2 * (W / 2) - 1) vld_last = 1'b1;
      end
      if (k == brk) lk_mark = obs_locked;
      if (k == 5) begin mid_i = obs_i; mid_q = obs_q; end
      if (k == 18) lk_18 = obs_locked;
    end
  endtask

  task automatic good_frame(input string req, input logic [W-1:0] iw, input logic [W-1:0] qw,
                            input logic [W-1:0] ei, input logic [W-1:0] eq);
    send_frame(iw, qw, -1);
    check(req, "valid count", vld_cnt, 1);
    check(req, "valid on last bit", vld_last, 1);
    check(req, "i_o", cap_i, ei);
    check(req, "q_o", cap_q, eq);
    check(req, "locked", obs_locked, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R4", "reset valid", valid, 0);
    check("R4", "reset locked", locked, 0);
    check("R4", "reset i_o", i_w, 0);
    check("R4", "reset q_o", q_w, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_acquire;
    for (int n = 0; n < 4; n++) begin
      drive_bit(1'b0, 1'b1, 1'b1);
      check("R4", "idle valid", obs_valid, 0);
      check("R4", "idle locked", obs_locked, 0);
    end
    send_frame(20'h12345, 20'hABCDE, -1);
    check("R3", "locked before frame end", lk_18, 0);
    check("R3", "locked after frame", obs_locked, 1);
    check("R5", "valid count", vld_cnt, 1);
    check("R5", "valid on last bit", vld_last, 1);
    check("R1", "i_o", cap_i, 20'h12345);
    check("R2", "q_o", cap_q, 20'hABCDE);
  endtask

  task automatic t_stream;
    good_frame("R1", 20'h7FFFF, 20'h80000, 20'h7FFFF, 20'h80000);
    good_frame("R2", 20'hFFFFF, 20'h00001, 20'hFFFFF, 20'h00001);
    check("R5", "i_o held mid frame", mid_i, 20'h7FFFF);
    check("R5", "q_o held mid frame", mid_q, 20'h80000);
    good_frame("R1", 20'h5A5A5, 20'hA5A5A, 20'h5A5A5, 20'hA5A5A);
  endtask

  task automatic t_swap;
    swap = 1'b1;
    good_frame("R7", 20'h11111, 20'h22222, 20'h22222, 20'h11111);
    swap = 1'b0;
  endtask

  task automatic t_neg;
    neg = 1'b1;
    good_frame("R8", 20'h00010, 20'h00003, 20'h00010, 20'h00000 - 20'h00003);
    good_frame("R8", 20'h00020, 20'h80000, 20'h00020, 20'h80000);
    swap = 1'b1;
    good_frame("R8", 20'h00100, 20'h00005, 20'h00000 - 20'h00005, 20'h00100);
    swap = 1'b0; neg = 1'b0;
  endtask

  task automatic t_break;
    send_frame(20'h33333, 20'h44444, 5);
    check("R6", "locked after bad high bit", lk_mark, 0);
    check("R6", "no valid in broken frame", vld_cnt, 0);
    good_frame("R6", 20'h0F0F0, 20'hF0F0F, 20'h0F0F0, 20'hF0F0F);
    send_frame(20'h55555, 20'h66666, 14);
    check("R6", "locked after bad low bit", lk_mark, 0);
    check("R6", "no valid in broken frame 2", vld_cnt, 0);
    good_frame("R6", 20'h00ABC, 20'hFF543, 20'h00ABC, 20'hFF543);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_acquire();
    t_stream();
    t_swap();
    t_neg();
    t_break();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule